// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two unsigned operands in a five-stage pipeline. The multiplicand is `MCAND_W` bits wide, the multiplier is six bits wide, and the product is `MCAND_W + 6` bits wide. With the default width this is a 6 x 6 to 12-bit multiply.

The first stage builds six shifted partial-product rows. Row i is the multiplicand gated by multiplier bit i and shifted left by i places. The next three stages reduce the rows with carry-save cells, each of which keeps its carries as a separate vector. The reduction goes from six rows to four, then to three, then to two. The last stage adds the two remaining rows with one carry-propagate addition.

Every stage ends in a register, and all of them share one clock. The block can therefore accept a new operand pair on every cycle and returns one product per cycle once the pipe is full. A valid flag travels alongside the data. Reset clears only the valid flags, so operands that are in flight when reset is asserted are discarded.

Top module: `mul_csa_pipe`

## Requirements
- R1: For every operand pair captured with `in_valid` high, `product` equals the unsigned product `a_in * b_in` at the full `MCAND_W + 6` bit width.
- R2: A pair captured at rising edge k appears on `product` with `out_valid` high directly after rising edge k+4. That is five register stages, so the pair is first visible in the fifth cycle counted from its capture edge.
- R3: Every carry-save cell preserves the arithmetic sum of its three input rows in its sum and carry outputs, modulo 2^(MCAND_W+6).
- R4: No carry is lost in the reduction tree. Even for the largest operands, the carry-save cells never produce a carry above the top bit of the product-width rows.
- R5: Pairs presented on consecutive cycles produce products on consecutive cycles, in the same order.
- R6: A cycle in which `in_valid` is low yields a cycle with `out_valid` low exactly five stages later, so the gaps in the input stream are kept in the output stream.
- R7: While `rst` is high at a rising edge, every stage's valid flag is cleared. Pairs in flight at that moment never appear with `out_valid` high.
- R8: The corner operands work: 0, 1, the all-ones value of each operand, and a single high bit. For example, 63 x 63 gives 3969 and 63 x 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stage registers |
| rst | input | 1 | Synchronous active-high reset; clears the valid flags only |
| in_valid | input | 1 | Marks `a_in`/`b_in` as an operand pair to capture |
| a_in | input | MCAND_W | Unsigned multiplicand |
| b_in | input | 6 | Unsigned multiplier; one partial-product row per bit |
| out_valid | output | 1 | Marks `product` as a finished result |
| product | output | MCAND_W+6 | Unsigned product |

## Verification
The bench builds the block with the default `MCAND_W` of 6, so both operand spaces are 64 values wide. It therefore streams all 4096 operand pairs back to back through the pipe, which covers every carry-save carry pattern, including the widest case of 63 x 63. Gap patterns in the input stream, a reset asserted while the pipe holds data, and an exact count of latency edges for a single pair are each checked against an independent five-deep model of valid flags and products.

// File: rtl/mulcsa_pkg.sv
package mulcsa_pkg;

    // Number of partial-product rows (equals the multiplier width).
    localparam int ROWS    = 6;
    // Register stages from operand capture to product.
    localparam int LATENCY = 5;

    // Row count left after one carry-save level: each group of three rows
    // becomes two, and the leftover rows pass through unchanged.
    function automatic int rows_after(input int n);
        return (n / 3) * 2 + (n % 3);
    endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c,
    output logic         cout
);
    logic [W-1:0] maj;

    always_comb begin
        s    = x ^ y ^ z;
        maj  = (x & y) | (x & z) | (y & z);
        c    = {maj[W-2:0], 1'b0};
        cout = maj[W-1];
    end

    // R3: sum and carry rows together keep the value of the three input rows
    always_comb begin
        a_r3_csa_sum: assert (W'(s + c) == W'(x + y + z));
    end

endmodule

// File: rtl/ppgen_stage.sv
module ppgen_stage #(
    parameter int AW   = 6,
    parameter int ROWS = 6,
    localparam int PW  = AW + ROWS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [AW-1:0]            a_in,
    input  logic [ROWS-1:0]          b_in,
    output logic                     out_valid,
    output logic [ROWS-1:0][PW-1:0]  out_rows
);
    typedef struct packed {
        logic                    vld;
        logic [ROWS-1:0][PW-1:0] rows;
    } pp_st_t;

    pp_st_t st_d, st_q;

    always_comb begin
        st_d.vld = in_valid;
        for (int i = 0; i < ROWS; i++) begin
            st_d.rows[i] = (PW'(a_in) & {PW{b_in[i]}}) << i;
        end
    end

    always_ff @(posedge clk) begin
        st_q.rows <= st_d.rows;
        if (rst) st_q.vld <= 1'b0;
        else     st_q.vld <= st_d.vld;
    end

    assign out_valid = st_q.vld;
    assign out_rows  = st_q.rows;

    // R6: the valid flag follows the input one stage later, gaps included
    a_r6_pp_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r6_pp_gap: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
    parameter int W    = 12,
    parameter int N_IN = 6,
    localparam int N_OUT = mulcsa_pkg::rows_after(N_IN),
    localparam int NCSA  = N_IN / 3,
    localparam int NPASS = N_IN % 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [N_IN-1:0][W-1:0]   in_rows,
    output logic                     out_valid,
    output logic [N_OUT-1:0][W-1:0]  out_rows
);
    typedef struct packed {
        logic                     vld;
        logic [N_OUT-1:0][W-1:0]  rows;
    } lvl_st_t;

    lvl_st_t st_d, st_q;

    logic [NCSA-1:0][W-1:0] sum_w;
    logic [NCSA-1:0][W-1:0] car_w;
    logic [NCSA-1:0]        lost_w;

    for (genvar g = 0; g < NCSA; g++) begin : g_cell
        csa_cell #(.W(W)) u_cell (
            .x   (in_rows[3*g]),
            .y   (in_rows[3*g+1]),
            .z   (in_rows[3*g+2]),
            .s   (sum_w[g]),
            .c   (car_w[g]),
            .cout(lost_w[g])
        );
    end

    always_comb begin
        st_d.vld = in_valid;
        for (int g = 0; g < NCSA; g++) begin
            st_d.rows[2*g]   = sum_w[g];
            st_d.rows[2*g+1] = car_w[g];
        end
        for (int p = 0; p < NPASS; p++) begin
            st_d.rows[2*NCSA+p] = in_rows[3*NCSA+p];
        end
    end

    always_ff @(posedge clk) begin
        st_q.rows <= st_d.rows;
        if (rst) st_q.vld <= 1'b0;
        else     st_q.vld <= st_d.vld;
    end

    assign out_valid = st_q.vld;
    assign out_rows  = st_q.rows;

    // R4: the carry dropped off the top of the rows is always zero for live data
    a_r4_no_carry_lost: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (lost_w == '0));

    // R6: the valid flag moves one level per edge, gaps included
    a_r6_lvl_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r6_lvl_gap: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/cpa_stage.sv
module cpa_stage #(
    parameter int W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0][W-1:0]  in_rows,
    output logic               out_valid,
    output logic [W-1:0]       result
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] sum;
    } fin_st_t;

    fin_st_t st_d, st_q;

    always_comb begin
        st_d.vld = in_valid;
        st_d.sum = in_rows[0] + in_rows[1];
    end

    always_ff @(posedge clk) begin
        st_q.sum <= st_d.sum;
        if (rst) st_q.vld <= 1'b0;
        else     st_q.vld <= st_d.vld;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.sum;

    // R6: the final stage keeps gaps and valid cycles aligned
    a_r6_cpa_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r6_cpa_gap: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/mul_csa_pipe.sv
module mul_csa_pipe #(
    parameter int MCAND_W = 6,
    localparam int MPLR_W = mulcsa_pkg::ROWS,
    localparam int PW     = MCAND_W + MPLR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [MCAND_W-1:0] a_in,
    input  logic [MPLR_W-1:0]  b_in,
    output logic               out_valid,
    output logic [PW-1:0]      product
);
    localparam int N1 = MPLR_W;
    localparam int N2 = mulcsa_pkg::rows_after(N1);
    localparam int N3 = mulcsa_pkg::rows_after(N2);
    localparam int N4 = mulcsa_pkg::rows_after(N3);

    logic                 v1, v2, v3, v4;
    logic [N1-1:0][PW-1:0] r1;
    logic [N2-1:0][PW-1:0] r2;
    logic [N3-1:0][PW-1:0] r3;
    logic [N4-1:0][PW-1:0] r4;

    ppgen_stage #(.AW(MCAND_W), .ROWS(MPLR_W)) u_pp (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in),
        .out_valid(v1), .out_rows(r1)
    );

    csa_stage #(.W(PW), .N_IN(N1)) u_lvl1 (
        .clk(clk), .rst(rst), .in_valid(v1), .in_rows(r1),
        .out_valid(v2), .out_rows(r2)
    );

    csa_stage #(.W(PW), .N_IN(N2)) u_lvl2 (
        .clk(clk), .rst(rst), .in_valid(v2), .in_rows(r2),
        .out_valid(v3), .out_rows(r3)
    );

    csa_stage #(.W(PW), .N_IN(N3)) u_lvl3 (
        .clk(clk), .rst(rst), .in_valid(v3), .in_rows(r3),
        .out_valid(v4), .out_rows(r4)
    );

    cpa_stage #(.W(PW)) u_cpa (
        .clk(clk), .rst(rst), .in_valid(v4), .in_rows(r4),
        .out_valid(out_valid), .result(product)
    );

    // R1, R2: a valid result is the product of the pair taken five edges earlier
    a_r1_product: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (product == PW'(PW'($past(a_in, 5)) * PW'($past(b_in, 5)))));
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 5));

endmodule

// File: tb/mul_csa_pipe_test.sv
`timescale 1ns/1ps
module mul_csa_pipe_test;
    localparam int AW = 6;
    localparam int BW = 6;
    localparam int PW = AW + BW;
    localparam int LAT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [AW-1:0] a_in = '0;
    logic [BW-1:0] b_in = '0;
    logic          out_valid;
    logic [PW-1:0] product;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic          mv [LAT];
    logic [PW-1:0] mp [LAT];

    always #10 clk = ~clk;

    mul_csa_pipe #(.MCAND_W(AW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .product(product)
    );

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < LAT; i++) begin
            mv[i] = 1'b0;
            mp[i] = '0;
        end
    endtask

    // One cycle: drive at negedge, clock, advance model, compare at negedge.
    task automatic step(input logic v, input int a, input int b, input string req);
        in_valid = v;
        a_in     = AW'(a);
        b_in     = BW'(b);
        @(posedge clk);
        for (int i = LAT - 1; i > 0; i--) begin
            mv[i] = mv[i-1];
            mp[i] = mp[i-1];
        end
        mv[0] = v;
        mp[0] = PW'(a) * PW'(b);
        @(negedge clk);
        check({req, " valid"}, PW'(out_valid), PW'(mv[LAT-1]));
        if (mv[LAT-1]) check({req, " product"}, product, mp[LAT-1]);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        model_clear();
        check("R7 reset valid", PW'(out_valid), '0);
        rst = 1'b0;
    endtask

    task automatic t_latency();
        int seen = 0;
        in_valid = 1'b1; a_in = AW'(5); b_in = BW'(7);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int n = 1; n <= LAT + 2; n++) begin
            if (out_valid && seen == 0) seen = n;
            if (n < LAT + 2) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        // seen counts edges from (and including) the capture edge
        check("R2 latency edges", PW'(seen), PW'(LAT));
        model_clear();
    endtask

    task automatic t_exhaustive();
        // R1, R3, R5: every pair back to back, results in order each cycle
        for (int a = 0; a < (1 << AW); a++)
            for (int b = 0; b < (1 << BW); b++)
                step(1'b1, a, b, "R1 R5 stream");
        drain("R5 drain");
    endtask

    task automatic t_corners();
        step(1'b1, 0, 0, "R8 zero");
        step(1'b1, 63, 63, "R4 R8 max");
        step(1'b1, 63, 0, "R8 a max b zero");
        step(1'b1, 0, 63, "R8 a zero b max");
        step(1'b1, 1, 63, "R8 one");
        step(1'b1, 32, 32, "R8 top bits");
        step(1'b1, 63, 1, "R8 one b");
        drain("R8 drain");
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 24; i++)
            step(((i % 3) != 1), (i * 11) % 64, (i * 5 + 3) % 64, "R6 gaps");
        drain("R6 drain");
    endtask

    task automatic t_reset_mid();
        step(1'b1, 9, 9, "R7 fill");
        step(1'b1, 10, 12, "R7 fill");
        step(1'b1, 33, 2, "R7 fill");
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        for (int i = 0; i < LAT + 1; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7 flushed", PW'(out_valid), '0);
        end
        step(1'b1, 21, 3, "R7 after reset");
        drain("R7 after reset");
    endtask

    initial begin
        model_clear();
        @(negedge clk);
        t_reset();
        t_latency();
        t_corners();
        t_bubbles();
        t_exhaustive();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule